// File: doc/BRIEF.md
# Serial EEPROM Target on I2C

This block is an I2C target that behaves like a 256-byte serial EEPROM. The bytes live in an on-chip register array. The block watches SCL and SDA, which are oversampled by the system clock. It answers on the bus only through an open-drain pull-down enable for SDA. A host addresses the block with a 7-bit device code and then sends a one-byte word address. After that it can write a single byte or up to a page of 16 bytes. It can also read back from the current address counter, read from a chosen address, or read a run of consecutive bytes.

Bytes sent in a write are first collected in a page-sized buffer. The array changes only when a Stop closes the write. The Stop also starts a fixed-length internal write cycle. During that cycle the block ignores the bus, so a host finds out when the cycle is over by retrying the device address until it is acknowledged. A lock input blocks every write to the array while reads carry on as usual.

Top module: `serial_eeprom_target`

## Requirements
- R1: A Start is a fall of SDA while SCL is high, and a Stop is a rise of SDA while SCL is high. A Start at any time outside the write cycle restarts decoding with a new device byte (repeated start).
- R2: The device byte is sent MSB first. Its bits 7:1 must equal binary 1010 followed by `dev_sel_i[2:0]`, and bit 0 set to 1 means read. A matching byte is acknowledged by pulling SDA low for the ninth clock. A byte that does not match gets no acknowledge, and the block stays silent until the next Start.
- R3: Incoming bits are taken on the rising edge of SCL. The block changes its SDA drive only while SCL is low. Read data goes out MSB first. After reset SDA is released.
- R4: In a write transfer, the first byte after the device byte is the word address. The block acknowledges it and loads it into the address counter.
- R5: The block acknowledges each data byte of a write and holds it in the page buffer. The array does not change until a Stop. If a Start comes before the Stop, the buffered bytes are dropped, and no write cycle follows.
- R6: A Stop that ends a write with at least one buffered byte writes the buffered bytes into the array. It also starts a write cycle of `WR_CYCLES` clocks. No device byte is acknowledged during the cycle. Once the cycle ends, the device byte is acknowledged again.
- R7: During a write, only the low 4 bits of the address counter step, and they wrap within the current 16-byte page. So the 17th byte of a page write overwrites the first byte.
- R8: While `wr_lock_i` is high, data bytes of a write get no acknowledge, the array keeps its contents, and a Stop starts no write cycle. The device byte, the word address and all reads are served normally.
- R9: A read that starts directly with a read device byte returns the byte at the address counter. The counter always points one past the last byte written or read.
- R10: A random read is a write device byte, then a word address, then a repeated Start and a read device byte. It returns the byte stored at that word address.
- R11: In a read, each acknowledge from the master sends the next byte. The counter steps through all 8 bits and wraps from 255 to 0. A NoAck followed by a Stop ends the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sensed level of the SDA line |
| dev_sel_i | input | 3 | Strap value for the low three device address bits |
| wr_lock_i | input | 1 | High blocks all writes to the array |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
An SCL edge at the pins takes two synchronizer clocks plus one register clock to change `sda_oe_o`. So an acknowledge or a read data bit appears about three clocks after the SCL fall that calls for it. The bench holds each SCL phase for four clocks and samples SDA in the middle of the high phase, well after that latency and before the next fall. The end of a write cycle is due `WR_CYCLES` clocks after the Stop is seen. The bench timestamps the Stop and the first acknowledged poll, and checks that the gap is at least `WR_CYCLES` and at most two poll lengths more. The device address is swept over every strap value against every candidate code. The whole array is written and read back with an arithmetic pattern.

// File: rtl/seep_pkg.sv
package seep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } seep_state_e;
endpackage

// File: rtl/seep_bus_edge.sv
module seep_bus_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q    <= scl_o;
      sda_d_q    <= sda_o;
    end
  end

  assign scl_o      = scl_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  // R1: SDA edges only count while SCL is held high across both samples
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/seep_wr_timer.sv
module seep_wr_timer #(
  parameter int CYCLES = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (start_i && cnt_q == '0)   cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6
  wr_cycle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/seep_page_buf.sv
module seep_page_buf #(
  parameter int PAGE_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         wr_i,
  input  logic [PAGE_W-1:0]            idx_i,
  input  logic [7:0]                   data_i,
  output logic [(1<<PAGE_W)-1:0]       valid_o,
  output logic [(1<<PAGE_W)*8-1:0]     data_o
);
  localparam int PAGE = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
        vld_q <= 1'b0;
      end else if (clear_i) begin
        vld_q <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(g)) begin
        ent_q <= data_i;
        vld_q <= 1'b1;
      end
    end

    assign valid_o[g]        = vld_q;
    assign data_o[g*8 +: 8]  = ent_q;
  end
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import seep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wr_lock_i,
  output logic       sda_oe_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_raw, stop_raw;
  logic busy, start_ev, stop_ev, byte_done, dev_hit, buf_wr, buf_clr, commit;
  logic [PAGE-1:0]   buf_vld;
  logic [PAGE*8-1:0] buf_data;
  logic [7:0]        rd_byte;

  seep_state_e       state_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q, out_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, rd_q, more_q;
  logic [7:0]        mem [DEPTH];

  seep_bus_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_raw), .stop_o(stop_raw)
  );

  seep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  seep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .clear_i(buf_clr), .wr_i(buf_wr),
    .idx_i(ptr_q[PAGE_W-1:0]), .data_i(sh_q), .valid_o(buf_vld), .data_o(buf_data)
  );

  // bus is blind while the write cycle runs
  assign start_ev  = start_raw & ~busy;
  assign stop_ev   = stop_raw & ~busy;
  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
  assign dev_hit   = (sh_q[7:1] == {DEV_CODE, dev_sel_i});
  assign buf_wr    = (state_q == ST_WDATA) && byte_done && !wr_lock_i;
  assign commit    = stop_ev && (|buf_vld) && !wr_lock_i;
  assign buf_clr   = start_ev | commit;
  assign rd_byte   = mem[ptr_q];
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      out_q     <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      rd_q      <= 1'b0;
      more_q    <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                rd_q    <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              ptr_q   <= sh_q[ADDR_W-1:0];
              oe_q    <= 1'b1;
              state_q <= ST_WADDR_ACK;
            end else if (!wr_lock_i) begin
              ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
              oe_q              <= 1'b1;
              state_q           <= ST_WDATA_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              out_q     <= rd_byte;
              oe_q      <= ~rd_byte[7];
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              oe_q      <= 1'b0;
              ptr_q     <= ptr_q + 1'b1;
              bit_cnt_q <= '0;
              state_q   <= ST_RACK;
            end else begin
              oe_q      <= ~out_q[6];
              out_q     <= {out_q[6:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_q <= ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              out_q   <= rd_byte;
              oe_q    <= ~rd_byte[7];
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // commit: all buffered bytes land in the counter's page at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (buf_vld[i]) mem[{ptr_q[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= buf_data[i*8 +: 8];
      end
    end
  end

  // R3
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s);
  // R6
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);
  // R7
  page_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));
  // R8
  lock_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock_i && state_q == ST_WDATA && byte_done) |=> !oe_q);
  // R2
  dev_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV && byte_done && !dev_hit) |=> !oe_q);
endmodule

// File: tb/serial_eeprom_target_tb.sv
module serial_eeprom_target_tb;
  localparam int WR_CYC = 600;
  localparam int Q      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic       lock = 1'b0;
  logic       oe;
  logic       sda_line;

  int n_chk = 0, n_bad = 0, cyc = 0, t_stop = 0, t_ack = 0;
  logic [7:0] mdl [256];
  logic [7:0] wbuf [32];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = sda_m & ~oe;

  serial_eeprom_target #(.WR_CYCLES(WR_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_sel_i(strap), .wr_lock_i(lock), .sda_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; t_stop = cyc; qw(); qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; qw(); scl = 1'b1; qw();
    ack = (sda_line == 1'b0);
    t_ack = cyc;
    qw(); scl = 1'b0; qw();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
    end
    sda_m = mack ? 1'b0 : 1'b1;
    qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic do_write(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte(a, ack);         chk(ack, "R4 waddr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk(ack, "R5 data ack", ack, 1);
      mdl[{a[7:4], 4'(a[3:0] + k[3:0])}] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic wait_cycle();
    logic ack;
    int tries = 0, t0;
    logic first_nack = 1'b0;
    t0 = t_stop;
    do begin
      bus_start();
      send_byte(dev(1'b0), ack);
      bus_stop();
      if (tries == 0) first_nack = !ack;
      tries++;
    end while (!ack && tries < 40);
    chk(first_nack, "R6 poll during cycle nacked", !first_nack, 0);
    chk(ack && (t_ack - t0 >= WR_CYC) && (t_ack - t0 <= WR_CYC + 400),
        "R6 cycle length", t_ack - t0, WR_CYC);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R10 dev w ack", ack, 1);
    send_byte(a, ack);         chk(ack, "R10 waddr ack", ack, 1);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R10 dev r ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, d);
      chk(d == mdl[8'(a + k)], req, d, mdl[8'(a + k)]);
    end
    bus_stop();
  endtask

  task automatic cur_read(input logic [7:0] a, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R9 dev r ack", ack, 1);
    get_byte(1'b0, d);
    chk(d == mdl[a], req, d, mdl[a]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    qw();
    chk(oe == 1'b0, "R3 reset releases sda", oe, 0);

    // R2 / R1: every strap against every candidate, plus a wrong family code
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        send_byte({4'b1010, 3'(c), 1'b0}, ack);
        chk(ack == (c == s), "R2 R1 address match", ack, c == s);
        bus_stop();
      end
      bus_start();
      send_byte({4'b1011, 3'(s), 1'b0}, ack);
      chk(!ack, "R2 wrong family", ack, 0);
      bus_stop();
    end
    strap = 3'b010;

    // R5 R6: fill the whole array one page at a time
    for (int pg = 0; pg < 16; pg++) begin
      for (int k = 0; k < 16; k++) wbuf[k] = 8'((pg * 16 + k) * 37 + 11);
      do_write(8'(pg * 16), 16);
      wait_cycle();
    end

    rand_read(8'h00, 256, "R11 sequential full sweep");
    cur_read(8'h00, "R9 R11 counter wrapped to 0");
    rand_read(8'hFE, 4, "R11 wrap 255 to 0");
    cur_read(8'h02, "R9 current address");

    // R5: repeated start drops buffered data
    bus_start();
    send_byte(dev(1'b0), ack); send_byte(8'h30, ack);
    send_byte(8'hAA, ack); chk(ack, "R5 data ack", ack, 1);
    bus_start();
    send_byte(dev(1'b0), ack); send_byte(8'h30, ack);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R1 repeated start", ack, 1);
    get_byte(1'b0, d);
    chk(d == mdl[8'h30], "R5 buffer dropped", d, mdl[8'h30]);
    bus_stop();
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R5 no write cycle", ack, 1);
    bus_stop();

    // R7: 18 bytes from 0x45 wrap within page 0x40
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'hC0 + k);
    do_write(8'h45, 18);
    wait_cycle();
    rand_read(8'h40, 17, "R7 page wrap");

    // single byte at end of page, counter wraps to page start
    wbuf[0] = 8'h3C;
    do_write(8'h7F, 1);
    wait_cycle();
    cur_read(8'h70, "R7 R9 counter wrapped in page");
    rand_read(8'h7F, 1, "R5 byte write");

    // R8: write lock
    lock = 1'b1;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R8 dev ack locked", ack, 1);
    send_byte(8'h60, ack);     chk(ack, "R8 waddr ack locked", ack, 1);
    send_byte(8'h5A, ack);     chk(!ack, "R8 data nack locked", ack, 0);
    bus_stop();
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, "R8 no write cycle", ack, 1);
    bus_stop();
    rand_read(8'h60, 2, "R8 array unchanged, reads work");
    lock = 1'b0;

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule